// File: doc/BRIEF.md
# Oversampling SPI Slave

This block is a serial-peripheral slave that lives entirely in the system clock domain. It does not use the external serial clock as a clock. The serial clock, the active-low select and the master-out data pin each pass through a synchronizer chain. Edges of the serial clock are then found by comparing successive synchronized samples. Because of this, the serial clock may run at no more than a quarter of the system clock.

While select is inactive, the block is idle. It withholds its output enable on the slave-out pin and ignores any activity on the clock pin. During this time the host may load the byte to be sent. While select is active, each detected sample edge captures one data bit and each detected shift edge moves the next transmit bit onto the output. Bits travel most significant first.

After a full byte, the received value is copied into a holding register and a completion flag rises. An interrupt line follows that flag when interrupts are enabled. If a held byte is overwritten before the host reads it, an overrun bit is set. Clock polarity and phase are chosen by two mode inputs.

Top module: `spi_oversample_slave`

## Requirements
- R1: After reset, miso_oe_o, done_o, ovr_o and irq_o are 0 and rx_data_o is 0.
- R2: While ss_n_i is high, miso_oe_o is 0, and toggling sck_i neither completes a byte nor moves the transmit byte.
- R3: A byte written with tx_wr_i while ss_n_i is high is sent most significant bit first once ss_n_i falls. With cpha_i = 0, its bit 7 is on miso_o with miso_oe_o = 1 before the first clock edge.
- R4: The leading edge is the transition away from the idle level given by cpol_i. With cpha_i = 0, data is captured on leading edges and the output advances on trailing edges. With cpha_i = 1, the output advances on leading edges and data is captured on trailing edges. This holds for all four combinations.
- R5: After the eighth capture, done_o becomes 1 and rx_data_o holds the received byte, with the first bit received at bit 7. irq_o equals done_o AND irq_en_i.
- R6: A one-cycle pulse on rx_rd_i clears done_o and ovr_o.
- R7: If a byte completes while done_o is still 1, rx_data_o takes the new byte and ovr_o becomes 1.
- R8: If ss_n_i rises partway through a byte, the partial byte is dropped without setting done_o, and the next selection starts again from bit 7.
- R9: A tx_wr_i pulse in the middle of a byte is ignored. A write made between bytes while ss_n_i stays low is accepted, even before the received byte is read, and it is sent as the next byte.
- R10: Bytes are received correctly when the sck_i period is four system clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| ss_n_i | input | 1 | Active-low select pin (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| irq_en_i | input | 1 | Interrupt enable |
| tx_wr_i | input | 1 | Load strobe for the transmit byte |
| tx_data_i | input | DW | Transmit byte |
| rx_rd_i | input | 1 | Read strobe; clears the completion and overrun flags |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| rx_data_o | output | DW | Holding register of the last received byte |
| done_o | output | 1 | Byte complete and not yet read |
| ovr_o | output | 1 | An unread byte was overwritten |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit word and a two-stage synchronizer. With these values, every mode, a full byte, an overrun and an aborted byte each take only a few hundred cycles. Most transfers run the serial clock with a half period of four system clocks, so that the returned data can be checked by the emulated master. One reception runs at the quarter-rate limit, where the two-stage synchronizer leaves no slack for capture.

// File: rtl/spi_oversample_slave.sv
module spi_oversample_slave #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          irq_en_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_rd_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          done_o,
  output logic          ovr_o,
  output logic          irq_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [SYNC-1:0] sck_p, ss_p, mosi_p;
  logic            sck_q;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   rx_sh, tx_sh, hold;
  logic            done_r, ovr_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
      sck_q  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC-2:0], sck_i};
      ss_p   <= {ss_p[SYNC-2:0], ss_n_i};
      mosi_p <= {mosi_p[SYNC-2:0], mosi_i};
      sck_q  <= sck_p[SYNC-1];
    end

  wire sck_s   = sck_p[SYNC-1];
  wire mosi_s  = mosi_p[SYNC-1];
  wire sel     = !ss_p[SYNC-1];
  wire toggled = sck_s != sck_q;
  wire lead    = toggled && (sck_q == cpol_i);
  wire trail   = toggled && (sck_s == cpol_i);
  wire cap_e   = sel && (cpha_i ? trail : lead);
  wire shift_e = sel && (cpha_i ? lead : trail) && (cnt != '0);
  wire last    = cap_e && (cnt == CW'(DW-1));
  wire tx_ld   = tx_wr_i && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      hold  <= '0;
    end else begin
      if (!sel)       cnt <= '0;
      else if (cap_e) cnt <= last ? '0 : cnt + 1'b1;
      if (cap_e)      rx_sh <= {rx_sh[DW-2:0], mosi_s};
      if (tx_ld)        tx_sh <= tx_data_i;
      else if (shift_e) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (last)       hold <= {rx_sh[DW-2:0], mosi_s};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_r <= 1'b0;
      ovr_r  <= 1'b0;
    end else begin
      if (last)         done_r <= 1'b1;
      else if (rx_rd_i) done_r <= 1'b0;
      if (last && done_r && !rx_rd_i) ovr_r <= 1'b1;
      else if (rx_rd_i)               ovr_r <= 1'b0;
    end

  assign miso_o    = tx_sh[DW-1];
  assign miso_oe_o = sel;
  assign rx_data_o = hold;
  assign done_o    = done_r;
  assign ovr_o     = ovr_r;
  assign irq_o     = done_r & irq_en_i;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |=> $stable(rx_data_o));
  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |=> cnt == '0);
  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> cnt == '0);
  p_read_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_i && !last |=> !done_o && !ovr_o);
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> done_o && $past(done_o));
  p_tx_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_i && cnt != '0 && !shift_e |=> $stable(miso_o));
endmodule

// File: tb/spi_oversample_slave_tb_top.sv
`timescale 1ns/1ps
module spi_oversample_slave_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, irq_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, miso_oe, done, ovr, irq;
  logic [7:0] rx_data;

  spi_oversample_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .cpol_i(cpol), .cpha_i(cpha), .irq_en_i(irq_en), .tx_wr_i(tx_wr),
    .tx_data_i(tx_data), .rx_rd_i(rx_rd), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_data_o(rx_data), .done_o(done), .ovr_o(ovr), .irq_o(irq));

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got, exp_b;
  logic done_prev = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
  endtask

  task automatic rd();
    rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p; cyc(6);
  endtask

  task automatic xfer(input logic [7:0] mo, input int hi, input int lo, input int h);
    for (int i = hi; i >= lo; i--) begin
      if (!cpha) begin
        mosi = mo[i]; cyc(h); got[i] = miso; sck = ~cpol; cyc(h); sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[i]; cyc(h); got[i] = miso; sck = cpol; cyc(h);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) chk("R5 unexpected completion", 1, 0);
      else begin
        exp_b = exp_q.pop_front();
        chk("R5 received byte", rx_data, exp_b);
      end
    end
    done_prev <= done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 miso_oe", miso_oe, 0); chk("R1 done", done, 0);
    chk("R1 ovr", ovr, 0); chk("R1 irq", irq, 0); chk("R1 rx_data", rx_data, 0);
    rst_n = 1'b1; cyc(3);

    set_mode(0, 0);
    wr(8'h81);
    mosi = 1'b1;
    for (int k = 0; k < 16; k++) begin sck = ~sck; cyc(4); end
    chk("R2 no completion while deselected", done, 0);
    chk("R2 rx_data untouched", rx_data, 0);
    chk("R2 miso_oe off", miso_oe, 0);
    ss_n = 1'b0; cyc(4);
    chk("R2 transmit byte not shifted", miso, 1);
    exp_q.push_back(8'h4E);
    xfer(8'h4E, 7, 0, 4); cyc(4);
    chk("R2 preload sent intact", got, 8'h81);
    rd(); ss_n = 1'b1; cyc(4);

    for (int m = 0; m < 4; m++) begin
      logic [7:0] t, o;
      t = 8'hA5 ^ 8'(m * 8'h13);
      o = 8'h3C + 8'(m * 8'h29);
      set_mode(m[1], m[0]);
      irq_en = m[0];
      wr(t);
      exp_q.push_back(o);
      ss_n = 1'b0; cyc(4);
      chk("R3 miso_oe on when selected", miso_oe, 1);
      if (!cpha) chk("R3 first bit before clock", miso, t[7]);
      xfer(o, 7, 0, 4); cyc(4);
      chk("R4 byte returned to master", got, t);
      chk("R5 done after eight bits", done, 1);
      chk("R5 irq follows enable", irq, irq_en);
      rd(); cyc(1);
      chk("R6 read clears done", done, 0);
      ss_n = 1'b1; cyc(4);
      chk("R2 miso_oe off after deselect", miso_oe, 0);
    end

    set_mode(0, 0);
    ss_n = 1'b0; cyc(4);
    exp_q.push_back(8'hE7);
    xfer(8'hE7, 7, 0, 2); cyc(4);
    chk("R10 done at quarter rate", done, 1);
    chk("R10 byte at quarter rate", rx_data, 8'hE7);
    rd(); ss_n = 1'b1; cyc(4);

    set_mode(1, 1);
    ss_n = 1'b0; cyc(4);
    exp_q.push_back(8'h11);
    xfer(8'h11, 7, 0, 4); cyc(4);
    xfer(8'h22, 7, 0, 4); cyc(4);
    chk("R7 overrun set", ovr, 1);
    chk("R7 newest byte held", rx_data, 8'h22);
    chk("R7 done still set", done, 1);
    rd(); cyc(1);
    chk("R6 read clears overrun", ovr, 0);
    chk("R6 read clears done", done, 0);
    ss_n = 1'b1; cyc(4);

    set_mode(0, 0);
    wr(8'hC3);
    ss_n = 1'b0; cyc(4);
    exp_q.push_back(8'h5A);
    xfer(8'h5A, 7, 4, 4);
    wr(8'hFF);
    xfer(8'h5A, 3, 0, 4); cyc(4);
    chk("R9 mid-byte write ignored", got, 8'hC3);
    wr(8'h96);
    rd(); cyc(1);
    exp_q.push_back(8'h21);
    xfer(8'h21, 7, 0, 4); cyc(4);
    chk("R9 write between bytes accepted", got, 8'h96);
    rd(); ss_n = 1'b1; cyc(4);

    set_mode(0, 1);
    wr(8'hAA);
    ss_n = 1'b0; cyc(4);
    xfer(8'hFF, 7, 5, 4);
    ss_n = 1'b1; cyc(6);
    chk("R8 aborted byte sets no done", done, 0);
    wr(8'h3C);
    ss_n = 1'b0; cyc(4);
    exp_q.push_back(8'h81);
    xfer(8'h81, 7, 0, 4); cyc(4);
    chk("R8 restart sends full byte", got, 8'h3C);
    chk("R8 restart receives full byte", rx_data, 8'h81);
    rd(); ss_n = 1'b1; cyc(4);

    chk("R5 all expected bytes seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule